// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the byte-wide register front end of a three-channel interval timer. A host reaches it through a two-bit address, an 8-bit write bus, an 8-bit read bus and single-cycle read and write strobes. The highest address is the control port. It takes configuration words, count-freeze commands and multi-channel read-back commands. The lower addresses are the data ports of the channels. Through them the host loads new count values and reads counts or status.

Each channel's counting datapath sits outside the block. Towards each channel the block drives a registered counting mode, a one-cycle load pulse and a 16-bit load value. From each channel it takes the live count and the output level. Byte sequencing happens here. For a 16-bit access, separate write and read byte pointers alternate between the low byte and the high byte. Each channel also holds a frozen count and a frozen status byte until the host has read them.

Top module: `timer_host_regs`

## Requirements
- R1: Address 3 is the control port and addresses 0 to 2 are the data ports of channels 0 to 2. A read of address 3 returns 0xFF and changes no channel state.
- R2: Control word fields: bits 7:6 select the channel (values 0 to 2), bits 5:4 give the access mode, bits 3:1 give the counting mode and bit 0 gives the BCD flag. A control word with a nonzero access mode stores these fields. The counting mode appears on that channel's `ch_mode` slice in the cycle after the write. Both byte pointers of the channel return to the low byte. No load pulse is produced.
- R3: Access mode 1 (low byte only): a data write loads {0x00, byte}, and a data read returns the live count bits 7:0.
- R4: Access mode 2 (high byte only): a data write loads {byte, 0x00}, and a data read returns the live count bits 15:8.
- R5: Access mode 3 (word): data writes alternate low byte then high byte, and only the high-byte write loads {high, low}. Live reads alternate low byte then high byte.
- R6: A load shows as a one-cycle pulse on the channel's `ch_load` bit in the cycle after the completing write, with the value on that channel's `ch_load_val` slice. At most one channel pulses in any cycle.
- R7: Access mode 0 freezes the selected channel's live count. Later reads return the frozen value in the channel's access-mode byte order. A freeze command issued while a frozen count is still unread is ignored.
- R8: Channel select 3 is a read-back command. Bit 1, 2 or 3 selects channel 0, 1 or 2. With bit 5 clear it freezes the counts of the selected channels, following R7. With bit 4 clear it freezes their status, except for a channel whose frozen status is still unread.
- R9: Status byte layout: bit 7 is the channel output level, bit 6 is 0, bits 5:4 are the access mode, bits 3:1 are the counting mode and bit 0 is the BCD flag.
- R10: A data read returns, in this order of priority: a frozen status, which is then cleared; a frozen count, which is cleared after its last byte (after the high byte in word mode); or the live count.
- R11: When a read strobe and a write strobe hit the same data port in one cycle, the read returns data according to the read pointer and the write acts according to the write pointer. Each pointer advances independently of the other.
- R12: After reset every channel is in access mode 1 with counting mode 0 and BCD 0. No count or status is frozen and no load pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 2 | Port address (3 = control) |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data, valid in the cycle of `rd_en` |
| ch_mode | output | 9 | Counting mode per channel, 3 bits each, channel 0 in the low bits |
| ch_load | output | 3 | Load pulse per channel |
| ch_load_val | output | 48 | Load value per channel, 16 bits each |
| ch_count | input | 48 | Live count per channel, 16 bits each |
| ch_out | input | 3 | Output level per channel |

## Verification
The port shares one address for reads and writes, so the two operations that can coincide are a read and a write to the same data port of a channel in word mode. The bench raises both strobes in the same cycle twice in a row. It then checks three things: that the returned bytes follow the live low-then-high order, that no load happens on the first cycle, and that a load of {second byte, first byte} happens after the second. A second overlap is state-based: a freeze command arrives while a frozen count or status is still pending. The bench judges this by changing the live inputs between the two commands and reading back the older values.

// File: rtl/timer_host_pkg.sv
package timer_host_pkg;

  // Byte sequencing modes carried in control word bits 5:4
  typedef enum logic [1:0] {
    ACC_FREEZE = 2'd0,
    ACC_LOW    = 2'd1,
    ACC_HIGH   = 2'd2,
    ACC_WORD   = 2'd3
  } acc_e;

  // Per-channel actions decoded from one control port write
  typedef struct packed {
    logic cfg_we;
    logic cnt_freeze;
    logic stat_freeze;
  } ch_cmd_t;

endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
  import timer_host_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int BYTE_W = 8
) (
  input  logic                      ctrl_we,
  input  logic [BYTE_W-1:1]         ctrl_byte,
  output ch_cmd_t [NUM_CH-1:0]      cmd
);
  localparam int SEL_LO = BYTE_W - 2;

  logic [1:0] sel;
  logic [1:0] acc;
  logic       readback;

  assign sel      = ctrl_byte[BYTE_W-1:SEL_LO];
  assign acc      = ctrl_byte[5:4];
  assign readback = (sel == 2'd3);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit;
    logic rb_hit;
    assign hit    = !readback && (sel == 2'(i));
    assign rb_hit = readback && ctrl_byte[i+1];
    assign cmd[i].cfg_we      = ctrl_we && hit && (acc != ACC_FREEZE);
    assign cmd[i].cnt_freeze  = ctrl_we && ((hit && (acc == ACC_FREEZE)) ||
                                            (rb_hit && !ctrl_byte[5]));
    assign cmd[i].stat_freeze = ctrl_we && rb_hit && !ctrl_byte[4];
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import timer_host_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int MODE_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  ch_cmd_t             cmd,
  input  logic                data_we,
  input  logic                data_re,
  input  logic [BYTE_W-1:0]   wdata,
  input  logic [2*BYTE_W-1:0] live_cnt,
  input  logic                out_lvl,
  output logic [MODE_W-1:0]   mode,
  output logic                load,
  output logic [2*BYTE_W-1:0] load_val,
  output logic [BYTE_W-1:0]   rdata
);
  localparam int CNT_W = 2 * BYTE_W;

  acc_e              acc_q;
  logic [MODE_W-1:0] mode_q;
  logic              bcd_q;
  logic              wr_hi_q;
  logic              rd_hi_q;
  logic [BYTE_W-1:0] lsb_q;
  logic [CNT_W-1:0]  frz_cnt_q;
  acc_e              frz_st_q;   // ACC_FREEZE means nothing frozen
  logic [BYTE_W-1:0] frz_stat_q;
  logic              frz_stat_v_q;
  logic              load_q;
  logic [CNT_W-1:0]  load_val_q;

  assign mode     = mode_q;
  assign load     = load_q;
  assign load_val = load_val_q;

  always_comb begin
    if (frz_stat_v_q) begin
      rdata = frz_stat_q;
    end else if (frz_st_q != ACC_FREEZE) begin
      rdata = (frz_st_q == ACC_HIGH) ? frz_cnt_q[CNT_W-1:BYTE_W] : frz_cnt_q[BYTE_W-1:0];
    end else begin
      case (acc_q)
        ACC_HIGH: rdata = live_cnt[CNT_W-1:BYTE_W];
        ACC_WORD: rdata = rd_hi_q ? live_cnt[CNT_W-1:BYTE_W] : live_cnt[BYTE_W-1:0];
        default:  rdata = live_cnt[BYTE_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q        <= ACC_LOW;
      mode_q       <= '0;
      bcd_q        <= 1'b0;
      wr_hi_q      <= 1'b0;
      rd_hi_q      <= 1'b0;
      lsb_q        <= '0;
      frz_cnt_q    <= '0;
      frz_st_q     <= ACC_FREEZE;
      frz_stat_q   <= '0;
      frz_stat_v_q <= 1'b0;
      load_q       <= 1'b0;
      load_val_q   <= '0;
    end else begin
      load_q <= 1'b0;

      if (cmd.cfg_we) begin
        acc_q   <= acc_e'(wdata[5:4]);
        mode_q  <= wdata[MODE_W:1];
        bcd_q   <= wdata[0];
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
      end else if (data_we) begin
        case (acc_q)
          ACC_HIGH: begin
            load_q     <= 1'b1;
            load_val_q <= {wdata, {BYTE_W{1'b0}}};
          end
          ACC_WORD: begin
            if (wr_hi_q) begin
              load_q     <= 1'b1;
              load_val_q <= {wdata, lsb_q};
            end else begin
              lsb_q <= wdata;
            end
            wr_hi_q <= !wr_hi_q;
          end
          default: begin
            load_q     <= 1'b1;
            load_val_q <= {{BYTE_W{1'b0}}, wdata};
          end
        endcase
      end

      if (data_re) begin
        if (frz_stat_v_q) begin
          frz_stat_v_q <= 1'b0;
        end else if (frz_st_q != ACC_FREEZE) begin
          frz_st_q <= (frz_st_q == ACC_WORD) ? ACC_HIGH : ACC_FREEZE;
        end else if (acc_q == ACC_WORD) begin
          rd_hi_q <= !rd_hi_q;
        end
      end

      if (cmd.cnt_freeze && (frz_st_q == ACC_FREEZE)) begin
        frz_cnt_q <= live_cnt;
        frz_st_q  <= acc_q;
      end

      if (cmd.stat_freeze && !frz_stat_v_q) begin
        frz_stat_q   <= {out_lvl, 1'b0, acc_q, mode_q, bcd_q};
        frz_stat_v_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/timer_host_regs.sv
module timer_host_regs
  import timer_host_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int BYTE_W = 8,
  parameter int MODE_W = 3,
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [BYTE_W-1:0]        wdata,
  output logic [BYTE_W-1:0]        rdata,
  output logic [NUM_CH*MODE_W-1:0] ch_mode,
  output logic [NUM_CH-1:0]        ch_load,
  output logic [NUM_CH*CNT_W-1:0]  ch_load_val,
  input  logic [NUM_CH*CNT_W-1:0]  ch_count,
  input  logic [NUM_CH-1:0]        ch_out
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);

  ch_cmd_t [NUM_CH-1:0]             cmd;
  logic    [NUM_CH-1:0][BYTE_W-1:0] ch_rdata;
  logic                             ctrl_we;

  assign ctrl_we = wr_en && (addr == CTRL_ADDR);

  tmr_cmd_decode #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_dec (
    .ctrl_we   (ctrl_we),
    .ctrl_byte (wdata[BYTE_W-1:1]),
    .cmd       (cmd)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    tmr_chan_regs #(.BYTE_W(BYTE_W), .MODE_W(MODE_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .cmd      (cmd[i]),
      .data_we  (wr_en && (addr == ADDR_W'(i))),
      .data_re  (rd_en && (addr == ADDR_W'(i))),
      .wdata    (wdata),
      .live_cnt (ch_count[i*CNT_W +: CNT_W]),
      .out_lvl  (ch_out[i]),
      .mode     (ch_mode[i*MODE_W +: MODE_W]),
      .load     (ch_load[i]),
      .load_val (ch_load_val[i*CNT_W +: CNT_W]),
      .rdata    (ch_rdata[i])
    );
  end

  always_comb begin
    rdata = '1;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(i)) rdata = ch_rdata[i];
    end
  end
endmodule

// File: rtl/timer_host_regs_chk.sv
module timer_host_regs_chk #(
  parameter int NUM_CH = 3,
  parameter int BYTE_W = 8,
  parameter int MODE_W = 3,
  parameter int ADDR_W = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_en,
  input logic                     rd_en,
  input logic [ADDR_W-1:0]        addr,
  input logic [BYTE_W-1:0]        rdata,
  input logic [NUM_CH*MODE_W-1:0] ch_mode,
  input logic [NUM_CH-1:0]        ch_load
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);

  AST_CTRL_READ_ONES: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == CTRL_ADDR) |-> (rdata == '1)); // R1

  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_load)); // R6

  AST_NO_LOAD_AFTER_CTRL: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == CTRL_ADDR) |=> (ch_load == '0)); // R2

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == CTRL_ADDR) |=> $stable(ch_mode)); // R2

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ld
    AST_LOAD_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
      ch_load[i] |-> ($past(wr_en) && $past(addr) == ADDR_W'(i))); // R6
  end
endmodule

bind timer_host_regs timer_host_regs_chk #(
  .NUM_CH(NUM_CH), .BYTE_W(BYTE_W), .MODE_W(MODE_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .ch_mode(ch_mode), .ch_load(ch_load)
);

// File: tb/timer_host_regs_tb_top.sv
`timescale 1ns/1ps
module timer_host_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_load;
  logic [47:0] ch_load_val;
  logic [47:0] ch_count = '0;
  logic [2:0]  ch_out = '0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic [2:0]  got_load;
  logic [47:0] got_val;
  logic [7:0]  got_rd;

  always #4 clk = ~clk;

  timer_host_regs dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ch_mode(ch_mode), .ch_load(ch_load),
    .ch_load_val(ch_load_val), .ch_count(ch_count), .ch_out(ch_out)
  );

  task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic set_cnt(int ch, logic [15:0] v);
    ch_count[ch*16 +: 16] = v;
  endtask

  task automatic bus(bit w, bit r, logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    #1 got_rd = rdata;
    @(posedge clk);
    #1;
    got_load = ch_load;
    got_val  = ch_load_val;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d); bus(1, 0, a, d); endtask
  task automatic rd(logic [1:0] a); bus(0, 1, a, 8'h00); endtask

  task automatic t_reset();
    chk("R12 load idle", 48'(ch_load), 48'h0);
    chk("R12 modes", 48'(ch_mode), 48'h0);
    set_cnt(0, 16'h5678);
    rd(2'd0); chk("R12 low-only read", 48'(got_rd), 48'h78);
    ch_out = 3'b101;
    wr(2'd3, 8'hE2);
    rd(2'd0); chk("R9 reset status", 48'(got_rd), 48'h90);
    rd(2'd0); chk("R10 status cleared", 48'(got_rd), 48'h78);
  endtask

  task automatic t_ctrl();
    wr(2'd3, 8'h75);
    chk("R2 no load", 48'(got_load), 48'h0);
    chk("R2 ch1 mode", 48'(ch_mode[5:3]), 48'h2);
  endtask

  task automatic t_word();
    set_cnt(1, 16'hBEEF);
    wr(2'd1, 8'h34); chk("R5 low byte no load", 48'(got_load), 48'h0);
    wr(2'd1, 8'h12);
    chk("R6 load pulse ch1", 48'(got_load), 48'h2);
    chk("R5 word value", 48'(got_val[31:16]), 48'h1234);
    rd(2'd1); chk("R5 read low", 48'(got_rd), 48'hEF);
    rd(2'd1); chk("R5 read high", 48'(got_rd), 48'hBE);
    rd(2'd1); chk("R5 read wraps", 48'(got_rd), 48'hEF);
    wr(2'd3, 8'h75);
    rd(2'd1); chk("R2 pointer reset", 48'(got_rd), 48'hEF);
  endtask

  task automatic t_low();
    wr(2'd3, 8'h16); chk("R2 ch0 mode", 48'(ch_mode[2:0]), 48'h3);
    wr(2'd0, 8'hAB);
    chk("R6 load pulse ch0", 48'(got_load), 48'h1);
    chk("R3 low-only load", 48'(got_val[15:0]), 48'h00AB);
    rd(2'd0); chk("R3 low-only read", 48'(got_rd), 48'h78);
  endtask

  task automatic t_high();
    set_cnt(2, 16'h9ABC);
    wr(2'd3, 8'hA0); chk("R2 ch2 mode", 48'(ch_mode[8:6]), 48'h0);
    wr(2'd2, 8'hCD);
    chk("R6 load pulse ch2", 48'(got_load), 48'h4);
    chk("R4 high-only load", 48'(got_val[47:32]), 48'hCD00);
    rd(2'd2); chk("R4 high-only read", 48'(got_rd), 48'h9A);
  endtask

  task automatic t_freeze();
    wr(2'd3, 8'h75);
    set_cnt(1, 16'hBEEF);
    wr(2'd3, 8'h40); chk("R7 freeze no load", 48'(got_load), 48'h0);
    set_cnt(1, 16'h1111);
    wr(2'd3, 8'h40);
    rd(2'd1); chk("R7 frozen low", 48'(got_rd), 48'hEF);
    rd(2'd1); chk("R7 second freeze ignored", 48'(got_rd), 48'hBE);
    rd(2'd1); chk("R10 live after frozen", 48'(got_rd), 48'h11);
  endtask

  task automatic t_readback();
    ch_out = 3'b101;
    set_cnt(0, 16'h5678);
    set_cnt(2, 16'h9ABC);
    wr(2'd3, 8'hCA);
    rd(2'd0); chk("R9 ch0 status", 48'(got_rd), 48'h96);
    set_cnt(0, 16'h0102);
    rd(2'd0); chk("R10 frozen count second", 48'(got_rd), 48'h78);
    rd(2'd0); chk("R10 live third", 48'(got_rd), 48'h02);
    rd(2'd2); chk("R8 ch2 status", 48'(got_rd), 48'hA0);
    set_cnt(2, 16'h3344);
    rd(2'd2); chk("R8 ch2 frozen high", 48'(got_rd), 48'h9A);
    rd(2'd2); chk("R10 ch2 live", 48'(got_rd), 48'h33);
  endtask

  task automatic t_stat_hold();
    ch_out = 3'b101;
    wr(2'd3, 8'hE4);
    ch_out = 3'b111;
    wr(2'd3, 8'hE4);
    rd(2'd1); chk("R8 status not refrozen", 48'(got_rd), 48'h35);
    rd(2'd1); chk("R10 status cleared ch1", 48'(got_rd), 48'h11);
  endtask

  task automatic t_ctrl_read();
    rd(2'd3); chk("R1 control read", 48'(got_rd), 48'hFF);
    rd(2'd0); chk("R1 data port unaffected", 48'(got_rd), 48'h02);
  endtask

  task automatic t_same_cycle();
    wr(2'd3, 8'h75);
    set_cnt(1, 16'h4321);
    bus(1, 1, 2'd1, 8'h99);
    chk("R11 read low", 48'(got_rd), 48'h21);
    chk("R11 no load yet", 48'(got_load), 48'h0);
    bus(1, 1, 2'd1, 8'h88);
    chk("R11 read high", 48'(got_rd), 48'h43);
    chk("R11 load pulse", 48'(got_load), 48'h2);
    chk("R11 load value", 48'(got_val[31:16]), 48'h8899);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #1;
    t_reset();
    t_ctrl();
    t_word();
    t_low();
    t_high();
    t_freeze();
    t_readback();
    t_stat_hold();
    t_ctrl_read();
    t_same_cycle();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule